// File: doc/BRIEF.md
# Scanned Converter Start and Channel Sequencer

This block drives a multichannel analog-to-digital converter. Software sets an eight-bit enable mask, a start source, a scan style and a clock divisor. The sequencer picks channels from the mask in ascending order and issues a start pulse for each conversion. When a conversion finishes it presents the result and sets a per-channel completion flag.

A conversion can be started in three ways: by a strobe that stands for the register write, by a timer overflow pulse, or by a chosen edge on an asynchronous pin. In full-scan style, one start converts every enabled channel once. In single-step style, one start converts the next enabled channel only, and the sequencer then waits for a fresh start. A behavioural converter model stands in for the analog part. It returns a computed result a fixed number of divided-clock ticks after each start.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Only channels whose bit is set in `cfg_mask` are converted. Disabled channels are skipped. Channels are visited in ascending index order.
- R2: With `cfg_step`=0, one start converts each enabled channel exactly once, lowest index first. `busy` then drops, and the next start again begins at the lowest enabled channel.
- R3: With `cfg_step`=1, one start converts exactly one channel. `busy` is low in the cycle its result appears, and no further conversion happens until another start arrives.
- R4: In single-step style, the walk continues from the channel after the last one converted. After the highest enabled channel it wraps to the lowest enabled channel.
- R5: `cfg_mode` codes are 0 = no start, 1 = strobe, 2 = timer, 3 = pin. In mode 1 an `imm_go` pulse starts a conversion. `imm_go` has no effect in any other mode.
- R6: In mode 2 a `tmr_ovf` pulse starts a conversion. Overflow pulses that arrive while `busy` is high are dropped and are not held for later.
- R7: In mode 3, `ext_trig` passes through a two-flop synchronizer. A rising edge starts a conversion when `cfg_edge_fall`=0, and a falling edge starts one when `cfg_edge_fall`=1. The opposite edge, and any edge seen while `busy` is high, has no effect.
- R8: When a conversion completes with `irq_en`=1, bit `irq_flag[ch]` is set. Each flag bit stays set until the matching `irq_clr` bit is pulsed. With `irq_en`=0 the flags are left unchanged.
- R9: `adc_tick` pulses once every `cfg_div`+1 clock cycles, which gives a divide ratio from 1 to 8.
- R10: While `cfg_mask` is all zeros, no start source begins a conversion.
- R11: Each result appears as a one-cycle `res_valid` pulse. It carries `res_chan` and `res_data` = channel×97+11, produced 4 divided ticks after the start pulse. After reset, `busy`, `res_valid` and `irq_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mask | input | 8 | Channel enable mask |
| cfg_mode | input | 2 | Start source select |
| cfg_step | input | 1 | 1 = single-step, 0 = full scan |
| cfg_edge_fall | input | 1 | Pin edge polarity, 1 = falling |
| cfg_div | input | 3 | Divisor minus one |
| imm_go | input | 1 | Software start strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_trig | input | 1 | Asynchronous trigger pin |
| irq_en | input | 1 | Completion flag enable |
| irq_clr | input | 8 | Per-channel flag clear pulses |
| busy | output | 1 | Conversion sequence in progress |
| adc_tick | output | 1 | Divided converter clock enable |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 3 | Channel of the result |
| res_data | output | 10 | Conversion result |
| irq_flag | output | 8 | Per-channel completion flags |

## Verification
On every cycle, the checker confirms four things. A start pulse never reaches the converter while it is still running. Every start targets a channel that was enabled. An all-zero mask keeps the sequencer idle. Flag bits only clear on request. It also checks the divided tick spacing against the divisor, and that `busy` is low whenever a single-step result appears. The bench scenarios cover the rest: the ascending visit order and the wrap from the highest channel to the lowest, the behaviour of each start source, and the choice of edge polarity. They also show that triggers arriving during a conversion are dropped rather than held, and that result values match the channel converted.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    SM_OFF  = 2'd0,
    SM_IMM  = 2'd1,
    SM_TMR  = 2'd2,
    SM_EDGE = 2'd3
  } start_mode_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       edge_fall,
  input  logic       imm_go,
  input  logic       tmr_ovf,
  input  logic       ext_trig,
  output logic       trig
);
  logic [2:0]  pin_sh;
  logic        edge_hit;
  start_mode_e sm;

  always_ff @(posedge clk) begin
    if (rst) pin_sh <= '0;
    else     pin_sh <= {pin_sh[1:0], ext_trig};
  end

  assign edge_hit = edge_fall ? (pin_sh[2] & ~pin_sh[1]) : (pin_sh[1] & ~pin_sh[2]);
  assign sm       = start_mode_e'(mode);

  always_comb begin
    unique case (sm)
      SM_IMM:  trig = imm_go;
      SM_TMR:  trig = tmr_ovf;
      SM_EDGE: trig = edge_hit;
      default: trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  from,
  output logic [CW-1:0]  idx,
  output logic           any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      int j;
      j = (int'(from) + i) % NCH;
      if (mask[j]) begin
        idx = CW'(j);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int NCH        = 8,
  parameter int RES_W      = 10,
  parameter int CONV_TICKS = 4,
  parameter int DMUL       = 97,
  parameter int DOFF       = 11,
  localparam int CW = $clog2(NCH),
  localparam int TW = $clog2(CONV_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CW-1:0]    chan,
  output logic             running,
  output logic             done,
  output logic [RES_W-1:0] data
);
  logic [TW-1:0] cnt;
  logic [CW-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      chan_q  <= '0;
      data    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        chan_q  <= chan;
      end else if (running && tick) begin
        if (cnt == TW'(CONV_TICKS - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
          data    <= RES_W'(int'(chan_q) * DMUL + DOFF);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NCH        = 8,
  parameter int DIV_W      = 3,
  parameter int RES_W      = 10,
  parameter int CONV_TICKS = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   cfg_mask,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_step,
  input  logic             cfg_edge_fall,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             imm_go,
  input  logic             tmr_ovf,
  input  logic             ext_trig,
  input  logic             irq_en,
  input  logic [NCH-1:0]   irq_clr,
  output logic             busy,
  output logic             adc_tick,
  output logic             res_valid,
  output logic [CW-1:0]    res_chan,
  output logic [RES_W-1:0] res_data,
  output logic [NCH-1:0]   irq_flag
);
  logic             trig;
  logic             conv_start;
  logic             conv_run;
  logic             conv_done;
  logic [RES_W-1:0] conv_data;
  logic [CW-1:0]    cur_chan;
  logic [CW-1:0]    ptr;
  logic [CW-1:0]    chan_inc;
  logic [CW-1:0]    pick_from;
  logic [CW-1:0]    pick_idx;
  logic             pick_any;

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(cfg_div), .tick(adc_tick)
  );

  adc_start_sel u_sel (
    .clk(clk), .rst(rst), .mode(cfg_mode), .edge_fall(cfg_edge_fall),
    .imm_go(imm_go), .tmr_ovf(tmr_ovf), .ext_trig(ext_trig), .trig(trig)
  );

  assign chan_inc  = (cur_chan == CW'(NCH - 1)) ? '0 : cur_chan + 1'b1;
  assign pick_from = busy ? chan_inc : ptr;

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask(cfg_mask), .from(pick_from), .idx(pick_idx), .any(pick_any)
  );

  adc_conv_stub #(.NCH(NCH), .RES_W(RES_W), .CONV_TICKS(CONV_TICKS)) u_conv (
    .clk(clk), .rst(rst), .tick(adc_tick), .start(conv_start), .chan(cur_chan),
    .running(conv_run), .done(conv_done), .data(conv_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      cur_chan   <= '0;
      ptr        <= '0;
      res_valid  <= 1'b0;
      res_chan   <= '0;
      res_data   <= '0;
      irq_flag   <= '0;
    end else begin
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      irq_flag   <= irq_flag & ~irq_clr;
      if (!busy) begin
        if (trig && pick_any) begin
          busy       <= 1'b1;
          conv_start <= 1'b1;
          cur_chan   <= pick_idx;
        end
      end else if (conv_done) begin
        res_valid <= 1'b1;
        res_chan  <= cur_chan;
        res_data  <= conv_data;
        if (irq_en) irq_flag[cur_chan] <= 1'b1;
        if (cfg_step) begin
          busy <= 1'b0;
          ptr  <= chan_inc;
        end else if (pick_any && pick_idx > cur_chan) begin
          conv_start <= 1'b1;
          cur_chan   <= pick_idx;
        end else begin
          busy <= 1'b0;
          ptr  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int NCH   = 8,
  parameter int DIV_W = 3,
  localparam int CW = $clog2(NCH),
  localparam int GW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   cfg_mask,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_step,
  input logic             busy,
  input logic             adc_tick,
  input logic             res_valid,
  input logic [NCH-1:0]   irq_flag,
  input logic [NCH-1:0]   irq_clr,
  input logic             conv_start,
  input logic [CW-1:0]    conv_chan,
  input logic             conv_run
);
  logic [NCH-1:0]   mask_q;
  logic [DIV_W-1:0] div_q;
  logic [GW-1:0]    gap;
  logic             seen;

  always_ff @(posedge clk) begin
    mask_q <= cfg_mask;
    div_q  <= cfg_div;
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (adc_tick) begin
        gap  <= GW'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (cfg_div != div_q) seen <= 1'b0;
    end
  end

  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !conv_run);

  p_start_enabled_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> mask_q[conv_chan]);

  p_zero_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_mask == '0) |=> !busy);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (|irq_flag) |=> ((irq_flag & $past(irq_flag & ~irq_clr)) == $past(irq_flag & ~irq_clr)));

  p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (adc_tick && seen && cfg_div == div_q) |-> (gap == GW'(cfg_div) + GW'(1)));

  p_step_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(cfg_step)) |-> !busy);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NCH(NCH), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cfg_div(cfg_div), .cfg_step(cfg_step),
  .busy(busy), .adc_tick(adc_tick), .res_valid(res_valid), .irq_flag(irq_flag),
  .irq_clr(irq_clr), .conv_start(conv_start), .conv_chan(cur_chan), .conv_run(conv_run)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
  localparam int NCH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_mask = '0;
  logic [1:0] cfg_mode = '0;
  logic       cfg_step = 1'b0;
  logic       cfg_edge_fall = 1'b0;
  logic [2:0] cfg_div = 3'd3;
  logic       imm_go = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       ext_trig = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] irq_clr = '0;
  logic       busy, adc_tick, res_valid;
  logic [2:0] res_chan;
  logic [9:0] res_data;
  logic [7:0] irq_flag;

  int n_run = 0;
  int n_fail = 0;
  int res_count = 0;
  int tb_ptr = 0;
  int exp_q[$];
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  adc_scan_ctrl u_adc_scan_ctrl (
    .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cfg_mode(cfg_mode), .cfg_step(cfg_step),
    .cfg_edge_fall(cfg_edge_fall), .cfg_div(cfg_div), .imm_go(imm_go), .tmr_ovf(tmr_ovf),
    .ext_trig(ext_trig), .irq_en(irq_en), .irq_clr(irq_clr), .busy(busy),
    .adc_tick(adc_tick), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .irq_flag(irq_flag)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_en(input logic [7:0] m, input int from);
    for (int i = 0; i < NCH; i++) begin
      if (m[(from + i) % NCH]) return (from + i) % NCH;
    end
    return -1;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      res_count++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 R6 R7", "unexpected result on channel", int'(res_chan), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(res_chan) == e, "R1 R2 R4", "result channel", int'(res_chan), e);
        chk(int'(res_data) == e * 97 + 11, "R11", "result data", int'(res_data), e * 97 + 11);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_imm();
    imm_go = 1'b1; cyc(1); imm_go = 1'b0;
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
  endtask

  task automatic wait_busy(input string req);
    int k = 0;
    while (!busy && k < 50) begin cyc(1); k++; end
    if (!busy) chk(1'b0, req, "busy never rose", 0, 1);
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 2000) begin cyc(1); k++; end
    if (busy) chk(1'b0, req, "busy never fell", 1, 0);
  endtask

  task automatic push_step(input logic [7:0] m);
    int ch;
    ch = next_en(m, tb_ptr);
    exp_q.push_back(ch);
    tb_ptr = (ch + 1) % NCH;
  endtask

  task automatic measure_tick(input int d);
    int n = 0;
    cfg_div = 3'(d);
    cyc(12);
    while (!adc_tick) cyc(1);
    cyc(1); n = 1;
    while (!adc_tick && n < 20) begin cyc(1); n++; end
    chk(n == d + 1, "R9", "tick period", n, d + 1);
  endtask

  initial begin
    int c0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk(busy == 1'b0, "R11", "busy after reset", int'(busy), 0);
    chk(res_valid == 1'b0, "R11", "res_valid after reset", int'(res_valid), 0);
    chk(irq_flag == 8'h00, "R11", "irq_flag after reset", int'(irq_flag), 0);

    measure_tick(0);
    measure_tick(3);
    measure_tick(7);
    cfg_div = 3'd3;
    cyc(4);

    // R2 full scan, strobe start
    cfg_mode = 2'd1; cfg_step = 1'b0; irq_en = 1'b1; cfg_mask = 8'hA5;
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(7);
    pulse_imm();
    wait_idle("R2");
    cyc(3);
    chk(exp_q.size() == 0, "R2", "scan results outstanding", exp_q.size(), 0);
    chk(irq_flag == 8'hA5, "R8", "flags after scan", int'(irq_flag), 8'hA5);
    cyc(20);
    chk(irq_flag == 8'hA5, "R8", "flags held", int'(irq_flag), 8'hA5);

    cfg_mask = 8'h18;
    exp_q.push_back(3); exp_q.push_back(4);
    pulse_imm();
    wait_idle("R2");
    cyc(3);
    chk(exp_q.size() == 0, "R2", "second scan outstanding", exp_q.size(), 0);

    irq_clr = 8'h21; cyc(1); irq_clr = 8'h00; cyc(1);
    chk(irq_flag == 8'h9C, "R8", "partial clear", int'(irq_flag), 8'h9C);
    irq_clr = 8'hFF; cyc(1); irq_clr = 8'h00; cyc(1);
    chk(irq_flag == 8'h00, "R8", "full clear", int'(irq_flag), 0);
    irq_en = 1'b0;

    // R5 strobe ignored outside mode 1
    cfg_mode = 2'd2; c0 = res_count;
    pulse_imm(); cyc(40);
    chk(res_count == c0 && !busy, "R5", "strobe in timer mode", res_count - c0, 0);
    cfg_mode = 2'd0;
    pulse_imm(); pulse_tmr(); cyc(40);
    chk(res_count == c0 && !busy, "R5", "starts in mode 0", res_count - c0, 0);

    // R3 R4 single-step with wrap
    cfg_mode = 2'd1; cfg_step = 1'b1; cfg_mask = 8'h4A; tb_ptr = 0;
    for (int s = 0; s < 4; s++) begin
      c0 = res_count;
      push_step(cfg_mask);
      pulse_imm();
      wait_idle("R3");
      cyc(40);
      chk(res_count == c0 + 1 && !busy, "R3", "one channel per start", res_count - c0, 1);
    end
    chk(tb_ptr == 2, "R4", "walk wrapped back to channel 1", tb_ptr, 2);

    // R6 timer start, overflow pulses while busy dropped
    cfg_mode = 2'd2; cfg_mask = 8'h81; c0 = res_count;
    push_step(cfg_mask);
    pulse_tmr(); cyc(2);
    for (int k = 0; k < 3; k++) begin pulse_tmr(); cyc(2); end
    wait_idle("R6");
    cyc(40);
    chk(res_count == c0 + 1 && !busy, "R6", "timer pulses during busy", res_count - c0, 1);

    // R7 rising edge, later edges during busy dropped
    cfg_mode = 2'd3; cfg_edge_fall = 1'b0; c0 = res_count;
    push_step(cfg_mask);
    ext_trig = 1'b1;
    wait_busy("R7");
    ext_trig = 1'b0; cyc(3); ext_trig = 1'b1; cyc(3); ext_trig = 1'b0;
    wait_idle("R7");
    cyc(40);
    chk(res_count == c0 + 1 && !busy, "R7", "edges during busy", res_count - c0, 1);

    // R7 falling polarity: rising edge has no effect
    cfg_edge_fall = 1'b1; cyc(5); c0 = res_count;
    ext_trig = 1'b1; cyc(20);
    chk(res_count == c0 && !busy, "R7", "rise with falling select", res_count - c0, 0);
    push_step(cfg_mask);
    ext_trig = 1'b0;
    wait_busy("R7");
    wait_idle("R7");
    cyc(40);
    chk(res_count == c0 + 1, "R7", "falling edge start", res_count - c0, 1);
    chk(irq_flag == 8'h00, "R8", "flags untouched with irq_en low", int'(irq_flag), 0);

    // R10 zero mask
    cfg_mask = 8'h00; cfg_mode = 2'd1; c0 = res_count;
    pulse_imm(); cyc(40);
    chk(res_count == c0 && !busy, "R10", "zero mask strobe", res_count - c0, 0);
    cfg_mode = 2'd2;
    pulse_tmr(); cyc(40);
    chk(res_count == c0 && !busy, "R10", "zero mask timer", res_count - c0, 0);

    chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule